// File: doc/BRIEF.md
# Vector String Search Comparator Array

This block scans a 128-bit string operand against a 128-bit compare operand and reports where the string matches. The operands are split into unsigned elements of 8, 16 or 32 bits. One cross-product array of comparators relates every string element to every compare element. The same array serves all three element widths, so it supplies 256, 64 or 16 useful comparisons. Four search kinds draw on it: position-wise equality, position-wise inequality, membership of a string element in the compare set, and interval tests against bound pairs held in the compare operand.

The result is either a byte mask, with each hitting element filled with ones, or the byte offset of the first hit. A 2-bit condition code comes with either form. When the terminator option is on, a zero string element marks the end of a C-style string. With the option off, the full vector is searched as a length-based string. The engine is fully pipelined. It takes one operation per clock and returns each result a fixed number of cycles later.

Top module: `vss_engine`

## Requirements
- R1: There are four register stages. Operands sampled at rising edge E produce `out_valid`, `out_res` and `out_cc` after edge E+3. A new operation is accepted every cycle, and `out_valid` repeats `in_valid` with that delay.
- R2: `in_esz` selects the element width: 0 = 8 bit (16 elements), 1 = 16 bit (8 elements), 2 or 3 = 32 bit (4 elements). Element 0 occupies the most significant bits of each operand. Elements compare as unsigned numbers.
- R3: `in_op` = 0 (find equal): string element i hits when it equals compare element i.
- R4: `in_op` = 1 (find not equal): string element i hits when it differs from compare element i.
- R5: `in_op` = 2 (find any equal): string element i hits when it equals at least one compare element.
- R6: `in_op` = 3 (range): compare elements 2k and 2k+1 form pair k. Each compare element j has the control nibble `in_rctl[4j+3:4j]`. Bit 0 passes on string == bound, bit 1 on string < bound, bit 2 on string > bound, and bit 3 always passes. A string element hits when, for some complete pair, both bounds pass.
- R7: `in_inv` = 1 complements every element hit before the result and condition code are formed.
- R8: With `in_idx` = 0, every byte of a hitting element is 0xFF and every other byte is 0x00.
- R9: With `in_idx` = 1, `out_res[4:0]` holds the byte offset of the first (lowest-numbered) hitting element, or 16 when none hits. All higher bits are zero.
- R10: With `in_zs` = 1, the first zero string element is the terminator. In index mode the offset is that of the earlier of the first hit and the terminator. In mask mode, hits in elements after the terminator are cleared. With `in_zs` = 0, zero elements have no special meaning.
- R11: `out_cc` is 3 when a hit and a terminator both exist and the hit comes first. It is 1 when a terminator exists and no hit precedes it. It is 2 when a hit exists and no terminator does. It is 0 when neither exists.
- R12: While `rst_n` is low at a rising edge, `out_valid`, `out_res` and `out_cc` are cleared to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Operation present this cycle |
| in_op | input | 2 | Search kind (R3 to R6) |
| in_esz | input | 2 | Element width select |
| in_zs | input | 1 | Zero-terminator option |
| in_inv | input | 1 | Complement element hits |
| in_idx | input | 1 | 1 = byte-offset result, 0 = mask result |
| in_str | input | 128 | String operand |
| in_cmp | input | 128 | Compare operand / range bounds |
| in_rctl | input | 64 | Range control nibbles, one per compare element |
| out_valid | output | 1 | Result present |
| out_res | output | 128 | Mask or byte offset |
| out_cc | output | 2 | Condition code |

## Verification
The bench streams operations back to back, with regular idle gaps. Each operation uses a different combination of search kind, element width, terminator option, invert and result form. Operands drawn from a four-symbol alphabet that includes zero make equalities, cross-matches and terminators frequent, so position-wise and cross-product matching give different answers and every condition code occurs. Operands with no zero bytes separate the terminator path from plain searches. Near-copies of the string in the compare operand, with random range controls, push the less/greater bound logic and the always-pass bit.

// File: rtl/vss_pkg.sv
// Shared types for the vector string search engine.
package vss_pkg;

    typedef enum logic [1:0] {
        OP_FEQ   = 2'd0,
        OP_FNE   = 2'd1,
        OP_FANY  = 2'd2,
        OP_RANGE = 2'd3
    } vss_op_e;

    // Per-operation controls carried down the pipeline; esz already normalised to 0..2
    typedef struct packed {
        vss_op_e    op;
        logic [1:0] esz;
        logic       zs;
        logic       inv;
        logic       idx;
    } vss_ctl_t;

endpackage

// File: rtl/vss_xbar.sv
// Cross-product comparator array.
// Splits both operands into elements of the selected width (element 0 in the
// most significant bits) and compares every string element with every
// compare element: equal, less-than, greater-than (unsigned). Pairs that fall
// outside the active element count read as zero. Also flags zero elements.
// Assumes esz is 0..2.
module vss_xbar #(
    parameter int VEC_W = 128,
    localparam int MAXE = VEC_W / 8
) (
    input  logic [1:0]           esz,
    input  logic [VEC_W-1:0]     str,
    input  logic [VEC_W-1:0]     cmp,
    output logic [MAXE*MAXE-1:0] eq,
    output logic [MAXE*MAXE-1:0] lt,
    output logic [MAXE*MAXE-1:0] gt,
    output logic [MAXE-1:0]      zero
);

    // Extract element idx of width 8<<sz, zero-extended to 32 bits
    function automatic logic [31:0] elem(input logic [VEC_W-1:0] v, input int idx,
                                         input logic [1:0] sz);
        logic [VEC_W-1:0] sh;
        logic [31:0]      top;
        sh  = v << (idx * (8 << sz));
        top = sh[VEC_W-1 -: 32];
        return top >> (32 - (8 << sz));
    endfunction

    logic [31:0]     ea [MAXE];
    logic [31:0]     eb [MAXE];
    logic [MAXE-1:0] act;

    for (genvar gi = 0; gi < MAXE; gi++) begin : g_lane
        assign ea[gi]   = elem(str, gi, esz);
        assign eb[gi]   = elem(cmp, gi, esz);
        assign act[gi]  = (gi < (MAXE >> esz));
        assign zero[gi] = act[gi] && (ea[gi] == 32'd0);
        for (genvar gj = 0; gj < MAXE; gj++) begin : g_col
            assign eq[gi*MAXE+gj] = act[gi] && act[gj] && (ea[gi] == eb[gj]);
            assign lt[gi*MAXE+gj] = act[gi] && act[gj] && (ea[gi] <  eb[gj]);
            assign gt[gi*MAXE+gj] = act[gi] && act[gj] && (ea[gi] >  eb[gj]);
        end
    end

endmodule

// File: rtl/vss_reduce.sv
// Folds the comparator matrix into one hit bit per string element according
// to the search kind, then applies the optional invert. Lanes beyond the
// active element count stay zero. Assumes the matrix is already lane-masked.
module vss_reduce #(
    parameter int MAXE = 16
) (
    input  vss_pkg::vss_op_e     op,
    input  logic                 inv,
    input  logic [1:0]           esz,
    input  logic [MAXE*MAXE-1:0] eq,
    input  logic [MAXE*MAXE-1:0] lt,
    input  logic [MAXE*MAXE-1:0] gt,
    input  logic [4*MAXE-1:0]    rctl,
    output logic [MAXE-1:0]      hit
);
    import vss_pkg::*;

    // Does string element i satisfy the bound held in compare element j
    function automatic logic bound_ok(input int i, input int j,
                                      input logic [MAXE*MAXE-1:0] e,
                                      input logic [MAXE*MAXE-1:0] l,
                                      input logic [MAXE*MAXE-1:0] g,
                                      input logic [4*MAXE-1:0] c,
                                      input logic live);
        return live && (c[4*j+3] || (c[4*j] && e[i*MAXE+j]) ||
                        (c[4*j+1] && l[i*MAXE+j]) || (c[4*j+2] && g[i*MAXE+j]));
    endfunction

    // Per-element reduction by search kind, then invert and lane mask
    always_comb begin
        for (int i = 0; i < MAXE; i++) begin
            logic h;
            logic act_i;
            act_i = (i < (MAXE >> esz));
            h     = 1'b0;
            unique case (op)
                OP_FEQ:  h = eq[i*MAXE+i];
                OP_FNE:  h = !eq[i*MAXE+i];
                OP_FANY: h = |eq[i*MAXE +: MAXE];
                default: begin
                    for (int k = 0; k < MAXE/2; k++) begin
                        logic pair_live;
                        pair_live = act_i && ((2*k+1) < (MAXE >> esz));
                        h = h || (bound_ok(i, 2*k, eq, lt, gt, rctl, pair_live) &&
                                  bound_ok(i, 2*k+1, eq, lt, gt, rctl, pair_live));
                    end
                end
            endcase
            hit[i] = act_i && (h ^ inv);
        end
    end

endmodule

// File: rtl/vss_locate.sv
// Turns element hits and zero flags into the final result: byte mask or
// byte offset of the first hit (bounded by the terminator when enabled),
// plus the condition code. Assumes hit/zero are zero beyond the active lanes.
module vss_locate #(
    parameter int MAXE = 16,
    localparam int IW = $clog2(MAXE) + 1
) (
    input  logic [MAXE-1:0]   hit,
    input  logic [MAXE-1:0]   zero,
    input  logic [1:0]        esz,
    input  logic              zs,
    input  logic              idx,
    output logic [8*MAXE-1:0] res,
    output logic [1:0]        cc
);

    logic [IW-1:0] n, fh, fz, first;

    // Priority search for first hit / first terminator, then result forming
    always_comb begin
        n  = IW'(MAXE >> esz);
        fh = n;
        fz = n;
        for (int i = MAXE-1; i >= 0; i--) begin
            if (hit[i])         fh = IW'(i);
            if (zs && zero[i])  fz = IW'(i);
        end
        first = (fh < fz) ? fh : fz;
        res   = '0;
        if (idx) begin
            res[IW-1:0] = IW'(first << esz);
        end else begin
            for (int b = 0; b < MAXE; b++) begin
                if (hit[b >> esz] && (IW'(b >> esz) <= fz))
                    res[8*(MAXE-1-b) +: 8] = 8'hFF;
            end
        end
        if ((fh < n) && (fz < n) && (fh < fz)) cc = 2'd3;
        else if (fz < n)                       cc = 2'd1;
        else if (fh < n)                       cc = 2'd2;
        else                                   cc = 2'd0;
    end

endmodule

// File: rtl/vss_engine.sv
// Vector string search engine, four register stages:
//   S1 operand capture, S2 comparator matrix, S3 element hits, S4 result.
// One operation per cycle, no stalls. Synchronous active-low reset.
module vss_engine #(
    parameter int VEC_W = 128,
    localparam int MAXE = VEC_W / 8,
    localparam int NCMP = MAXE * MAXE,
    localparam int IW   = $clog2(MAXE) + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [1:0]         in_op,
    input  logic [1:0]         in_esz,
    input  logic               in_zs,
    input  logic               in_inv,
    input  logic               in_idx,
    input  logic [VEC_W-1:0]   in_str,
    input  logic [VEC_W-1:0]   in_cmp,
    input  logic [4*MAXE-1:0]  in_rctl,
    output logic               out_valid,
    output logic [VEC_W-1:0]   out_res,
    output logic [1:0]         out_cc
);
    import vss_pkg::*;

    logic               s1_v, s2_v, s3_v;
    vss_ctl_t           s1_c, s2_c, s3_c;
    logic [VEC_W-1:0]   s1_str, s1_cmp;
    logic [4*MAXE-1:0]  s1_rctl, s2_rctl;
    logic [NCMP-1:0]    x_eq, x_lt, x_gt, s2_eq, s2_lt, s2_gt;
    logic [MAXE-1:0]    x_zero, s2_zero, s3_zero, r_hit, s3_hit;
    logic [VEC_W-1:0]   l_res;
    logic [1:0]         l_cc;
    logic               o_idx;

    // S1: capture operands, fold width code 3 onto 32-bit elements
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v <= 1'b0; s1_c <= '0; s1_str <= '0; s1_cmp <= '0; s1_rctl <= '0;
        end else begin
            s1_v    <= in_valid;
            s1_c    <= '{op: vss_op_e'(in_op), esz: (in_esz == 2'd3) ? 2'd2 : in_esz,
                         zs: in_zs, inv: in_inv, idx: in_idx};
            s1_str  <= in_str;
            s1_cmp  <= in_cmp;
            s1_rctl <= in_rctl;
        end
    end

    vss_xbar #(.VEC_W(VEC_W)) u_xbar (
        .esz(s1_c.esz), .str(s1_str), .cmp(s1_cmp),
        .eq(x_eq), .lt(x_lt), .gt(x_gt), .zero(x_zero)
    );

    // S2: register the comparator matrix
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_v <= 1'b0; s2_c <= '0; s2_rctl <= '0;
            s2_eq <= '0; s2_lt <= '0; s2_gt <= '0; s2_zero <= '0;
        end else begin
            s2_v <= s1_v; s2_c <= s1_c; s2_rctl <= s1_rctl;
            s2_eq <= x_eq; s2_lt <= x_lt; s2_gt <= x_gt; s2_zero <= x_zero;
        end
    end

    vss_reduce #(.MAXE(MAXE)) u_reduce (
        .op(s2_c.op), .inv(s2_c.inv), .esz(s2_c.esz),
        .eq(s2_eq), .lt(s2_lt), .gt(s2_gt), .rctl(s2_rctl), .hit(r_hit)
    );

    // S3: register element hits and terminator flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s3_v <= 1'b0; s3_c <= '0; s3_hit <= '0; s3_zero <= '0;
        end else begin
            s3_v <= s2_v; s3_c <= s2_c; s3_hit <= r_hit; s3_zero <= s2_zero;
        end
    end

    vss_locate #(.MAXE(MAXE)) u_locate (
        .hit(s3_hit), .zero(s3_zero), .esz(s3_c.esz), .zs(s3_c.zs),
        .idx(s3_c.idx), .res(l_res), .cc(l_cc)
    );

    // S4: output registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0; out_res <= '0; out_cc <= 2'd0; o_idx <= 1'b0;
        end else begin
            out_valid <= s3_v; out_res <= l_res; out_cc <= l_cc; o_idx <= s3_c.idx;
        end
    end

    // R1: the last stage forwards the valid bit of the stage before it
    p_valid_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        s3_v |=> out_valid);
    p_idle_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !s3_v |=> !out_valid);
    // R9: an offset result never exceeds the vector byte count, upper bits clear
    p_index_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && o_idx) |-> (out_res[IW-1:0] <= IW'(MAXE) && out_res[VEC_W-1:IW] == '0));
    // R11: code 0 in index form reports the no-hit offset
    p_cc_none_index_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && o_idx && out_cc == 2'd0) |-> out_res[IW-1:0] == IW'(MAXE));
    // R8: code 0 in mask form leaves the mask empty
    p_cc_none_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !o_idx && out_cc == 2'd0) |-> out_res == '0);

endmodule

// File: tb/tb_vss_engine.sv
`timescale 1ns/1ps
module tb_vss_engine;

    localparam int NSLOT = 900;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [1:0]   in_op = '0, in_esz = '0;
    logic         in_zs = 1'b0, in_inv = 1'b0, in_idx = 1'b0;
    logic [127:0] in_str = '0, in_cmp = '0;
    logic [63:0]  in_rctl = '0;
    logic         out_valid;
    logic [127:0] out_res;
    logic [1:0]   out_cc;

    int checks = 0;
    int errors = 0;

    logic         e_v   [NSLOT];
    logic [127:0] e_res [NSLOT];
    logic [1:0]   e_cc  [NSLOT];
    string        e_tag [NSLOT];

    vss_engine dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_esz(in_esz), .in_zs(in_zs), .in_inv(in_inv), .in_idx(in_idx),
        .in_str(in_str), .in_cmp(in_cmp), .in_rctl(in_rctl),
        .out_valid(out_valid), .out_res(out_res), .out_cc(out_cc)
    );

    always #4 clk = ~clk;

    // Element i of B bytes, counted from the most significant end
    function automatic logic [31:0] el(input logic [127:0] v, input int i, input int b);
        logic [127:0] t;
        logic [31:0]  m;
        t = v >> (128 - 8*b*(i+1));
        m = (b == 4) ? 32'hFFFF_FFFF : ((32'd1 << (8*b)) - 32'd1);
        return t[31:0] & m;
    endfunction

    function automatic logic bnd(input logic [31:0] v, input logic [31:0] bd,
                                 input logic [3:0] c);
        return c[3] || (c[0] && v == bd) || (c[1] && v < bd) || (c[2] && v > bd);
    endfunction

    // Reference result built from the requirements
    task automatic model(input int op, input int esz, input bit zs, input bit inv,
                         input bit idx, input logic [127:0] s, input logic [127:0] c,
                         input logic [63:0] rc, output logic [127:0] res,
                         output logic [1:0] cc);
        int b, n, fh, fz, first;
        bit hit [16];
        b = (esz == 3) ? 4 : (1 << esz);
        n = 16 / b;
        for (int i = 0; i < 16; i++) hit[i] = 1'b0;
        for (int i = 0; i < n; i++) begin
            bit h;
            logic [31:0] si;
            si = el(s, i, b);
            h  = 1'b0;
            case (op)
                0: h = (si == el(c, i, b));
                1: h = (si != el(c, i, b));
                2: for (int j = 0; j < n; j++) if (si == el(c, j, b)) h = 1'b1;
                default:
                    for (int k = 0; 2*k+1 < n; k++)
                        if (bnd(si, el(c, 2*k, b), rc[8*k +: 4]) &&
                            bnd(si, el(c, 2*k+1, b), rc[8*k+4 +: 4])) h = 1'b1;
            endcase
            hit[i] = h ^ inv;
        end
        fh = n; fz = n;
        for (int i = n-1; i >= 0; i--) begin
            if (hit[i]) fh = i;
            if (zs && el(s, i, b) == 32'd0) fz = i;
        end
        res = '0;
        if (idx) begin
            first = (fh < fz) ? fh : fz;
            res = 128'(first * b);
        end else begin
            for (int i = 0; i < n; i++)
                if (hit[i] && i <= fz)
                    for (int k = 0; k < b; k++) res[127 - 8*(i*b+k) -: 8] = 8'hFF;
        end
        if (fh < n && fz < n && fh < fz) cc = 2'd3;
        else if (fz < n)                 cc = 2'd1;
        else if (fh < n)                 cc = 2'd2;
        else                             cc = 2'd0;
    endtask

    function automatic string op_tag(input int op);
        case (op)
            0: return "R3";
            1: return "R4";
            2: return "R5";
            default: return "R6";
        endcase
    endfunction

    logic [31:0] seed = 32'h1234_5678;
    function automatic logic [31:0] nxt(inout logic [31:0] sd);
        sd = sd * 32'd1664525 + 32'd1013904223;
        return sd;
    endfunction

    // Drive slot t (or an idle slot) and record its expected result
    task automatic drive_slot(input int t, inout int c);
        logic [127:0] s, cv, r;
        logic [63:0]  rc;
        logic [1:0]   cc;
        int op, esz, mode;
        bit zs, inv, idx;
        if (t >= NSLOT || (t % 13) == 12) begin
            in_valid = 1'b0;
            if (t < NSLOT) e_v[t] = 1'b0;
            return;
        end
        op = c % 4; esz = (c / 4) % 4; zs = ((c / 16) % 2) != 0;
        inv = ((c / 32) % 2) != 0; idx = ((c / 64) % 2) != 0; mode = (c / 128) % 3;
        for (int k = 0; k < 16; k++) begin
            logic [31:0] a, d;
            a = nxt(seed); d = nxt(seed);
            case (mode)
                0: begin s[127-8*k -: 8] = {6'd0, a[17:16]}; cv[127-8*k -: 8] = {6'd0, d[17:16]}; end
                1: begin s[127-8*k -: 8] = {6'd0, a[17:16]} + 8'd1; cv[127-8*k -: 8] = {6'd0, d[17:16]} + 8'd1; end
                default: begin
                    s[127-8*k -: 8]  = a[23:16];
                    cv[127-8*k -: 8] = (d[19:18] == 2'd0) ? d[31:24] : a[23:16];
                end
            endcase
        end
        rc = {nxt(seed), nxt(seed)};
        if (mode != 2) rc = rc & {16{4'b0111}};
        model(op, esz, zs, inv, idx, s, cv, rc, r, cc);
        e_v[t] = 1'b1; e_res[t] = r; e_cc[t] = cc;
        e_tag[t] = $sformatf("%s/R2%s%s%s", op_tag(op), idx ? "/R9" : "/R8",
                             zs ? "/R10" : "", inv ? "/R7" : "");
        in_valid = 1'b1; in_op = 2'(op); in_esz = 2'(esz);
        in_zs = zs; in_inv = inv; in_idx = idx;
        in_str = s; in_cmp = cv; in_rctl = rc;
        c++;
    endtask

    task automatic check_slot(input int t);
        checks++;
        if (out_valid !== e_v[t]) begin
            errors++;
            $display("FAIL R1 slot %0d out_valid actual %0b expected %0b", t, out_valid, e_v[t]);
        end
        if (e_v[t]) begin
            checks++;
            if (out_res !== e_res[t]) begin
                errors++;
                $display("FAIL %s slot %0d out_res actual %h expected %h", e_tag[t], t, out_res, e_res[t]);
            end
            checks++;
            if (out_cc !== e_cc[t]) begin
                errors++;
                $display("FAIL R11 (%s) slot %0d out_cc actual %0d expected %0d", e_tag[t], t, out_cc, e_cc[t]);
            end
        end
    endtask

    initial begin
        int c;
        c = 0;
        // R12: reset with an operation presented at the inputs
        in_valid = 1'b1; in_idx = 1'b1;
        repeat (5) @(posedge clk);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_res !== '0 || out_cc !== 2'd0) begin
            errors++;
            $display("FAIL R12 reset outputs actual v=%0b res=%h cc=%0d expected 0/0/0",
                     out_valid, out_res, out_cc);
        end
        in_valid = 1'b0;
        rst_n = 1'b1;
        // Streaming: at each negedge check slot t-4, then drive slot t (R1)
        for (int t = 0; t < NSLOT + 4; t++) begin
            if (t >= 4) check_slot(t - 4);
            drive_slot(t, c);
            @(negedge clk);
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 8);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule